// File: doc/BRIEF.md
# CAN Controller Mode State Machine

This block keeps track of the operating mode of a CAN protocol controller. It combines the software reset and enable controls, the loopback, sleep and snoop requests and the bus-off recovery controls with flags from the rest of the controller. Those flags are the transmit error count, the 11-recessive-bit detector and the protocol-exception detector. From them it picks exactly one of seven modes and reports that mode on a one-hot status vector.

Mode requests are taken only while the controller sits in configuration mode. Once the controller is running, only three things move it: losing the enable, the error count crossing the bus-off threshold, and the exception and sleep-wake conditions. Bus-off recovery counts 11-recessive-bit events. The counting is either automatic or armed by software. Interrupt lines give a single-cycle pulse when bus-off starts, when bus-off ends and when the protocol-exception state is entered.

Top module: `can_mode_ctrl`

## Requirements
- R1: An active-low hard reset, or `sw_rst` sampled high at a clock edge, puts the block in configuration mode. Status then reads 7'b0000001, and `sw_rst` takes precedence over every other input.
- R2: While `enable` is 0 the next mode is configuration, from any mode and whatever the request bits hold.
- R3: In configuration mode, with `enable` at 1 and all three requests at 0, the next mode is normal (status bit 1).
- R4: In configuration mode with `enable` at 1, a single request selects its mode. Loopback sets status bit 4, snoop sets bit 2 and sleep sets bit 3.
- R5: If two or three requests are set, the request is invalid and the block stays in configuration mode.
- R6: Request bits are ignored outside configuration mode. The one exception is the sleep wake of R10.
- R7: From normal, snoop, sleep, loopback or exception mode, `tec` strictly greater than BUSOFF_LIMIT enters bus-off (status bit 5). `tec` equal to BUSOFF_LIMIT does not. In bus-off the request bits are ignored.
- R8: Bus-off ends in normal mode on the RECOV_SEQ-th `recessive_seq` pulse that is counted. A pulse counts only while `auto_recover` is 1 or after `sw_recover` has been seen during the current bus-off. Pulses outside those conditions do not count.
- R9: From normal mode, `pex_detect` with `pex_disable` at 0 enters the exception mode (status bit 6). With `pex_disable` at 1 the mode stays normal. `pex_exit` returns exception mode to normal.
- R10: Sleep mode returns to normal when `req_sleep` is 0 or `bus_activity` is 1.
- R11: `irq_busoff_enter`, `irq_busoff_exit` and `irq_pex_enter` are high for exactly the first cycle in which status bit 5 rises, bit 5 falls or bit 6 rises, respectively.
- R12: Exactly one status bit is set in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset bit |
| enable | input | 1 | Controller enable bit |
| req_lback | input | 1 | Loopback request |
| req_sleep | input | 1 | Sleep request |
| req_snoop | input | 1 | Snoop (listen-only) request |
| auto_recover | input | 1 | Automatic bus-off recovery |
| sw_recover | input | 1 | Software recovery request pulse |
| pex_disable | input | 1 | Blocks entry to protocol exception |
| tec | input | TEC_W | Transmit error count |
| recessive_seq | input | 1 | Pulse per 11 consecutive recessive bits |
| bus_activity | input | 1 | Bus activity seen, wakes sleep |
| pex_detect | input | 1 | Protocol exception condition |
| pex_exit | input | 1 | Exception exit condition (bus idle) |
| status | output | 7 | One-hot mode: 0 config, 1 normal, 2 snoop, 3 sleep, 4 loopback, 5 bus-off, 6 exception |
| irq_busoff_enter | output | 1 | Pulse on bus-off entry |
| irq_busoff_exit | output | 1 | Pulse on bus-off exit |
| irq_pex_enter | output | 1 | Pulse on exception entry |

## Verification
The bench builds the block with RECOV_SEQ at 4 and keeps TEC_W at 9 and BUSOFF_LIMIT at 255. The short recovery count lets complete bus-off recoveries, both automatic and software-armed, happen many times within a short run, including the counted-pulse boundary one pulse before release. The default width and limit leave the 255/256 threshold edge reachable, so the strictly-greater comparison is exercised exactly where it matters.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  localparam int NUM_MODES = 7;

  // Encoding doubles as the status bit index.
  typedef enum logic [2:0] {
    MD_CFG   = 3'd0,
    MD_NORM  = 3'd1,
    MD_SNOOP = 3'd2,
    MD_SLEEP = 3'd3,
    MD_LBACK = 3'd4,
    MD_BOFF  = 3'd5,
    MD_PEX   = 3'd6
  } mode_e;

  function automatic logic [NUM_MODES-1:0] mode_onehot(input mode_e m);
    logic [NUM_MODES-1:0] v;
    v = '0;
    v[int'(m)] = 1'b1;
    return v;
  endfunction

  function automatic logic tec_exceeds(input int unsigned count,
                                       input int unsigned limit);
    return count > limit;
  endfunction

endpackage

// File: rtl/can_mode_req_dec.sv
module can_mode_req_dec
  import can_mode_pkg::*;
(
  input  logic  req_lback,
  input  logic  req_sleep,
  input  logic  req_snoop,
  output mode_e req_mode,
  output logic  req_conflict
);

  always_comb begin
    req_conflict = 1'b0;
    case ({req_lback, req_snoop, req_sleep})
      3'b000:  req_mode = MD_NORM;
      3'b100:  req_mode = MD_LBACK;
      3'b010:  req_mode = MD_SNOOP;
      3'b001:  req_mode = MD_SLEEP;
      default: begin
        req_mode     = MD_CFG;
        req_conflict = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/can_busoff_recov.sv
module can_busoff_recov #(
  parameter int RECOV_SEQ = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_boff,
  input  logic auto_recover,
  input  logic sw_recover,
  input  logic recessive_seq,
  output logic recov_done
);

  localparam int CW = $clog2(RECOV_SEQ + 1);
  localparam logic [CW-1:0] LAST = CW'(RECOV_SEQ - 1);

  logic [CW-1:0] seq_cnt_q;
  logic          armed_q;
  logic          seq_counted;

  assign seq_counted = in_boff && recessive_seq &&
                       (auto_recover || armed_q || sw_recover);
  assign recov_done  = seq_counted && (seq_cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_cnt_q <= '0;
      armed_q   <= 1'b0;
    end else if (!in_boff) begin
      seq_cnt_q <= '0;
      armed_q   <= 1'b0;
    end else begin
      if (sw_recover) armed_q <= 1'b1;
      if (seq_counted && !recov_done) seq_cnt_q <= seq_cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/can_edge_pulse.sv
module can_edge_pulse #(
  parameter int W = 1,
  parameter logic [W-1:0] FALLING = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] pulse
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level[i];
    end
    if (FALLING[i]) begin : g_fall
      assign pulse[i] = prev_q & ~level[i];
    end else begin : g_rise
      assign pulse[i] = level[i] & ~prev_q;
    end
  end

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int TEC_W        = 9,
  parameter int BUSOFF_LIMIT = 255,
  parameter int RECOV_SEQ    = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_rst,
  input  logic                 enable,
  input  logic                 req_lback,
  input  logic                 req_sleep,
  input  logic                 req_snoop,
  input  logic                 auto_recover,
  input  logic                 sw_recover,
  input  logic                 pex_disable,
  input  logic [TEC_W-1:0]     tec,
  input  logic                 recessive_seq,
  input  logic                 bus_activity,
  input  logic                 pex_detect,
  input  logic                 pex_exit,
  output logic [NUM_MODES-1:0] status,
  output logic                 irq_busoff_enter,
  output logic                 irq_busoff_exit,
  output logic                 irq_pex_enter
);

  localparam int unsigned LIMIT_U = BUSOFF_LIMIT;

  mode_e state_q, state_d;
  mode_e req_mode;
  logic  req_conflict;

  // Named internal events
  logic busoff_hit;
  logic pex_enter;
  logic sleep_wake;
  logic recov_done;
  logic in_boff;
  logic [2:0] edge_pulse;

  assign busoff_hit = tec_exceeds(32'(tec), LIMIT_U);
  assign pex_enter  = pex_detect && !pex_disable;
  assign sleep_wake = !req_sleep || bus_activity;
  assign in_boff    = (state_q == MD_BOFF);

  can_mode_req_dec u_req_dec (
    .req_lback    (req_lback),
    .req_sleep    (req_sleep),
    .req_snoop    (req_snoop),
    .req_mode     (req_mode),
    .req_conflict (req_conflict)
  );

  can_busoff_recov #(.RECOV_SEQ(RECOV_SEQ)) u_recov (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_boff       (in_boff),
    .auto_recover  (auto_recover),
    .sw_recover    (sw_recover),
    .recessive_seq (recessive_seq),
    .recov_done    (recov_done)
  );

  always_comb begin
    state_d = state_q;
    if (sw_rst || !enable) begin
      state_d = MD_CFG;
    end else begin
      case (state_q)
        MD_CFG:  if (!req_conflict) state_d = req_mode;
        MD_BOFF: if (recov_done) state_d = MD_NORM;
        default: begin
          if (busoff_hit)                             state_d = MD_BOFF;
          else if (state_q == MD_NORM && pex_enter)   state_d = MD_PEX;
          else if (state_q == MD_PEX && pex_exit)     state_d = MD_NORM;
          else if (state_q == MD_SLEEP && sleep_wake) state_d = MD_NORM;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MD_CFG;
    else        state_q <= state_d;
  end

  assign status = mode_onehot(state_q);

  can_edge_pulse #(.W(3), .FALLING(3'b010)) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .level ({status[MD_PEX], status[MD_BOFF], status[MD_BOFF]}),
    .pulse (edge_pulse)
  );

  assign irq_busoff_enter = edge_pulse[0];
  assign irq_busoff_exit  = edge_pulse[1];
  assign irq_pex_enter    = edge_pulse[2];

endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk #(
  parameter int TEC_W        = 9,
  parameter int BUSOFF_LIMIT = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_rst,
  input logic             enable,
  input logic             req_lback,
  input logic             req_sleep,
  input logic             req_snoop,
  input logic             pex_disable,
  input logic [TEC_W-1:0] tec,
  input logic             recessive_seq,
  input logic [6:0]       status,
  input logic             irq_busoff_enter,
  input logic             irq_busoff_exit,
  input logic             irq_pex_enter
);

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status) == 1); // R12

  AST_SWRST_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> status[0]); // R1

  AST_DISABLED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> status[0]); // R2

  AST_MULTI_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && enable && !sw_rst &&
     ($countones({req_lback, req_sleep, req_snoop}) > 1)) |=> status[0]); // R5

  AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[0] && !status[5] && enable && !sw_rst &&
     (int'(tec) > BUSOFF_LIMIT)) |=> status[5]); // R7

  AST_BUSOFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && enable && !sw_rst && !recessive_seq) |=> status[5]); // R8

  AST_PEX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && pex_disable) |=> !status[6]); // R9

  AST_BOFF_IRQ_IN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_busoff_enter == $rose(status[5])); // R11

  AST_BOFF_IRQ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_busoff_exit == $fell(status[5])); // R11

  AST_PEX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pex_enter == $rose(status[6])); // R11

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_busoff_enter |=> !irq_busoff_enter); // R11

endmodule

bind can_mode_ctrl can_mode_chk #(
  .TEC_W        (TEC_W),
  .BUSOFF_LIMIT (BUSOFF_LIMIT)
) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .sw_rst           (sw_rst),
  .enable           (enable),
  .req_lback        (req_lback),
  .req_sleep        (req_sleep),
  .req_snoop        (req_snoop),
  .pex_disable      (pex_disable),
  .tec              (tec),
  .recessive_seq    (recessive_seq),
  .status           (status),
  .irq_busoff_enter (irq_busoff_enter),
  .irq_busoff_exit  (irq_busoff_exit),
  .irq_pex_enter    (irq_pex_enter)
);

// File: tb/can_mode_ctrl_tb.sv
`timescale 1ns/1ps
module can_mode_ctrl_tb_top;

  localparam int TEC_W = 9;
  localparam int LIMIT = 255;
  localparam int RSEQ  = 4;

  // Mode numbers equal status bit positions (see requirements).
  localparam int M_CFG = 0, M_NORM = 1, M_SNOOP = 2, M_SLEEP = 3,
                 M_LBACK = 4, M_BOFF = 5, M_PEX = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rst = 0, enable = 0, req_lback = 0, req_sleep = 0, req_snoop = 0;
  logic auto_recover = 0, sw_recover = 0, pex_disable = 0;
  logic [TEC_W-1:0] tec = '0;
  logic recessive_seq = 0, bus_activity = 0, pex_detect = 0, pex_exit = 0;
  logic [6:0] status;
  logic irq_busoff_enter, irq_busoff_exit, irq_pex_enter;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  can_mode_ctrl #(.TEC_W(TEC_W), .BUSOFF_LIMIT(LIMIT), .RECOV_SEQ(RSEQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .enable(enable),
    .req_lback(req_lback), .req_sleep(req_sleep), .req_snoop(req_snoop),
    .auto_recover(auto_recover), .sw_recover(sw_recover),
    .pex_disable(pex_disable), .tec(tec), .recessive_seq(recessive_seq),
    .bus_activity(bus_activity), .pex_detect(pex_detect), .pex_exit(pex_exit),
    .status(status), .irq_busoff_enter(irq_busoff_enter),
    .irq_busoff_exit(irq_busoff_exit), .irq_pex_enter(irq_pex_enter)
  );

  // Behavioural reference model
  int m_mode = M_CFG;
  int m_prev = M_CFG;
  int m_cnt = 0;
  bit m_armed = 0;

  always @(posedge clk) begin
    int nxt;
    int nreq;
    if (!rst_n) begin
      m_mode = M_CFG; m_prev = M_CFG; m_cnt = 0; m_armed = 0;
    end else begin
      nreq = int'(req_lback) + int'(req_sleep) + int'(req_snoop);
      nxt = m_mode;
      if (sw_rst || !enable) nxt = M_CFG;
      else if (m_mode == M_CFG) begin
        if (nreq == 0) nxt = M_NORM;
        else if (nreq == 1) nxt = req_lback ? M_LBACK : (req_snoop ? M_SNOOP : M_SLEEP);
      end else if (m_mode == M_BOFF) begin
        if (recessive_seq && (auto_recover || m_armed || sw_recover)) m_cnt++;
        if (sw_recover) m_armed = 1;
        if (m_cnt >= RSEQ) nxt = M_NORM;
      end else if (int'(tec) > LIMIT) nxt = M_BOFF;
      else if (m_mode == M_NORM && pex_detect && !pex_disable) nxt = M_PEX;
      else if (m_mode == M_PEX && pex_exit) nxt = M_NORM;
      else if (m_mode == M_SLEEP && (!req_sleep || bus_activity)) nxt = M_NORM;
      if (nxt != M_BOFF) begin m_cnt = 0; m_armed = 0; end
      m_prev = m_mode;
      m_mode = nxt;
    end
  end

  task automatic check_val(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check_val("R12 model status", int'(status), 1 << m_mode);
      check_val("R11 model irq_busoff_enter", int'(irq_busoff_enter),
                int'(m_mode == M_BOFF && m_prev != M_BOFF));
      check_val("R11 model irq_busoff_exit", int'(irq_busoff_exit),
                int'(m_mode != M_BOFF && m_prev == M_BOFF));
      check_val("R11 model irq_pex_enter", int'(irq_pex_enter),
                int'(m_mode == M_PEX && m_prev != M_PEX));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_mode(string tag, int m);
    check_val(tag, int'(status), 1 << m);
  endtask

  task automatic rec_pulse();
    recessive_seq = 1; tick(); recessive_seq = 0; tick();
  endtask

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1;
    expect_mode("R1 reset state", M_CFG);
    tick();
    expect_mode("R2 enable low holds config", M_CFG);
    enable = 1; tick();
    expect_mode("R3 normal entry", M_NORM);
    req_lback = 1; tick(2);
    expect_mode("R6 request ignored in normal", M_NORM);
    enable = 0; tick();
    expect_mode("R2 disable returns config", M_CFG);
    enable = 1; tick();
    expect_mode("R4 loopback select", M_LBACK);
    enable = 0; req_lback = 0; req_snoop = 1; tick();
    enable = 1; tick();
    expect_mode("R4 snoop select", M_SNOOP);
    enable = 0; req_snoop = 0; req_sleep = 1; tick();
    enable = 1; tick();
    expect_mode("R4 sleep select", M_SLEEP);
    tick();
    expect_mode("R10 sleep holds", M_SLEEP);
    bus_activity = 1; tick(); bus_activity = 0;
    expect_mode("R10 wake on activity", M_NORM);
    enable = 0; tick(); enable = 1; tick();
    expect_mode("R4 sleep again", M_SLEEP);
    req_sleep = 0; tick();
    expect_mode("R10 wake on sleep clear", M_NORM);
    enable = 0; req_lback = 1; req_snoop = 1; tick();
    enable = 1; tick(3);
    expect_mode("R5 conflicting requests", M_CFG);
    req_lback = 0; req_snoop = 0; tick();
    expect_mode("R3 normal after conflict cleared", M_NORM);
    tec = 9'd255; tick(2);
    expect_mode("R7 limit not crossed", M_NORM);
    tec = 9'd256; tick();
    expect_mode("R7 bus-off entry", M_BOFF);
    check_val("R11 bus-off enter pulse", int'(irq_busoff_enter), 1);
    tick();
    check_val("R11 bus-off enter single cycle", int'(irq_busoff_enter), 0);
    req_lback = 1; tec = '0; tick();
    expect_mode("R7 request ignored in bus-off", M_BOFF);
    req_lback = 0;
    repeat (6) rec_pulse();
    expect_mode("R8 unarmed pulses not counted", M_BOFF);
    sw_recover = 1; tick(); sw_recover = 0; tick();
    repeat (RSEQ - 1) rec_pulse();
    expect_mode("R8 one pulse short", M_BOFF);
    recessive_seq = 1; tick(); recessive_seq = 0;
    expect_mode("R8 software recovery done", M_NORM);
    check_val("R11 bus-off exit pulse", int'(irq_busoff_exit), 1);
    tick();
    check_val("R11 bus-off exit single cycle", int'(irq_busoff_exit), 0);
    pex_disable = 1; pex_detect = 1; tick(2);
    expect_mode("R9 exception blocked", M_NORM);
    pex_disable = 0; tick();
    expect_mode("R9 exception entry", M_PEX);
    check_val("R11 exception pulse", int'(irq_pex_enter), 1);
    pex_detect = 0; pex_exit = 1; tick(); pex_exit = 0;
    expect_mode("R9 exception exit", M_NORM);
    auto_recover = 1; tec = 9'd300; tick(); tec = '0;
    expect_mode("R7 bus-off entry again", M_BOFF);
    repeat (RSEQ) rec_pulse();
    expect_mode("R8 automatic recovery", M_NORM);
    auto_recover = 0;
    sw_rst = 1; tick();
    expect_mode("R1 software reset", M_CFG);
    tick(); sw_rst = 0; tick();
    expect_mode("R3 normal after software reset", M_NORM);

    for (int i = 0; i < 3000; i++) begin
      sw_rst        = ($urandom_range(0, 49) == 0);
      enable        = ($urandom_range(0, 19) != 0);
      req_lback     = ($urandom_range(0, 5) == 0);
      req_sleep     = ($urandom_range(0, 5) == 0);
      req_snoop     = ($urandom_range(0, 5) == 0);
      auto_recover  = ($urandom_range(0, 3) == 0);
      sw_recover    = ($urandom_range(0, 9) == 0);
      pex_disable   = ($urandom_range(0, 1) == 0);
      pex_detect    = ($urandom_range(0, 9) == 0);
      pex_exit      = ($urandom_range(0, 4) == 0);
      bus_activity  = ($urandom_range(0, 9) == 0);
      recessive_seq = ($urandom_range(0, 1) == 0);
      tec = ($urandom_range(0, 15) == 0) ? TEC_W'($urandom_range(250, 511))
                                         : TEC_W'($urandom_range(0, 255));
      tick();
    end
    finish_run();
  end

endmodule